// File: doc/BRIEF.md
# Serial Port DMA Engine

This block moves bytes between system memory and a byte-wide serial port. It has two channels. A transmit channel reads a block of bytes from memory and hands them, in address order, to the serial transmitter. A receive channel writes received bytes to memory. Both channels share one byte-wide memory master port that carries one access at a time.

Software programs each channel through four write-only register strobes: a start address and a length for each direction. Writing a transmit length starts the fetch loop at once. Writing a receive length first empties whatever the receive FIFO already holds, up to the requested length, into memory. If the FIFO held too few bytes, the rest of the length stays pending. While a length is pending, the serial front end must steer new bytes into this engine instead of into the FIFO; the `rx_divert` output tells it when to do so. Each steered byte goes straight to memory.

The register block reads back the pointers, the pending receive length and the busy flags from this engine.

Top module: `serial_dma_engine`

## Requirements
- R1: After a synchronous active-low reset, both busy flags, `mem_req`, `tx_valid`, `rx_divert` and `rx_remaining` are 0, and both pointers are 0.
- R2: A non-zero transmit length N fetches N bytes from consecutive addresses, starting at `tx_ptr`. Each byte is presented on `tx_data` in fetch order. `tx_ptr` rises by one per byte sent and ends at start+N.
- R3: A transmit length of zero starts nothing: `tx_busy` stays low, no byte is sent and `tx_ptr` is unchanged.
- R4: While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged. No fetched byte is lost or sent twice.
- R5: `mem_req` remains asserted, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack`. Only one access is outstanding at a time. `mem_we`=1 marks a write, which the receive channel issues; `mem_we`=0 marks a read, which the transmit channel issues.
- R6: A receive length N with `fifo_count` >= N drains exactly N bytes, oldest first, to consecutive addresses from `rx_ptr`. `rx_ptr` ends at start+N and `rx_remaining` is 0. `fifo_pop` pulses once per byte and only while the FIFO is non-empty.
- R7: A receive length N with `fifo_count` = C < N drains all C bytes and sets `rx_remaining` to N-C.
- R8: While `rx_remaining` is non-zero, `rx_divert` is high. When the channel is idle, `rx_in_ready` is also high. Each accepted input byte is written to `rx_ptr`, after which `rx_ptr` increments and `rx_remaining` decrements. When `rx_remaining` reaches zero, `rx_divert` falls.
- R9: Writing the receive address loads `rx_ptr` and clears `rx_remaining` to zero, which cancels any pending receive.
- R10: A channel is busy while a transmit fetch/send, a receive drain or a diverted byte write is in progress. Any register write to a busy channel is ignored. Select codes on `cfg_wr_sel`: 0 = transmit address, 1 = transmit length, 2 = receive address, 3 = receive length.
- R11: When both channels request memory in the same cycle, the receive channel is served first. Both transfers then complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select (see R10) |
| cfg_wdata | input | ADDR_W | Write value; lengths use the low LEN_W bits |
| tx_ptr | output | ADDR_W | Next transmit fetch address |
| rx_ptr | output | ADDR_W | Next receive write address |
| rx_remaining | output | LEN_W | Pending receive length |
| tx_busy | output | 1 | Transmit channel active |
| rx_busy | output | 1 | Receive channel active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts byte |
| fifo_count | input | FCNT_W | Bytes held in receive FIFO |
| fifo_data | input | 8 | Oldest FIFO byte |
| fifo_pop | output | 1 | Remove oldest FIFO byte |
| rx_in_valid | input | 1 | Received byte offered for direct write |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Direct byte accepted |
| rx_divert | output | 1 | Front end must steer bytes here, not to the FIFO |

## Verification
A table of receive cases covers the drain split: a FIFO holding more bytes than requested, exactly as many, fewer, none, and a zero request. A wrong comparison would leave bytes stranded or set the wrong `rx_remaining`. Directed tests send diverted bytes until the pending length runs out, so an off-by-one would keep `rx_divert` high or write to the wrong address. A rewrite of the receive address must zero the pending length; a design that fails this keeps diverting. Transmit is exercised with a zero length, which must not hang in the busy state. It also runs with a toggling `tx_ready`, which exposes dropped or repeated bytes. Further tests write registers while a channel is busy, where corruption would shift the end pointer, and start both channels together, where a broken arbiter would mix addresses or lose an ack.

// File: rtl/sdma_pkg.sv
// Shared types for the serial DMA engine.
// Assumes: the register select is a 2-bit code driven by the register block.
package sdma_pkg;

    // Register write targets; code values are visible on cfg_wr_sel
    typedef enum logic [1:0] {
        SEL_TX_ADDR = 2'd0,
        SEL_TX_LEN  = 2'd1,
        SEL_RX_ADDR = 2'd2,
        SEL_RX_LEN  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_FETCH = 2'd1,
        TXS_SEND  = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RXS_IDLE   = 2'd0,
        RXS_LOAD   = 2'd1,
        RXS_DRAIN  = 2'd2,
        RXS_DIRECT = 2'd3
    } rx_state_e;

endpackage

// File: rtl/sdma_mem_arb.sv
// Memory port sharing for the two channels.
// Does: forwards one channel's request to the memory master port, receive first,
//       and keeps the chosen owner until that access is acknowledged.
// Assumes: each channel holds its request and payload steady until its ack.
module sdma_mem_arb #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_req,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [7:0]        rx_wdata,
    output logic              rx_ack,
    input  logic              tx_req,
    input  logic [ADDR_W-1:0] tx_addr,
    output logic              tx_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack
);
    logic locked_q;
    logic own_rx_q;
    logic pick_rx;

    // Owner choice: the locked owner, otherwise receive has priority
    always_comb begin
        pick_rx   = locked_q ? own_rx_q : rx_req;
        mem_req   = pick_rx ? rx_req : tx_req;
        mem_we    = pick_rx;
        mem_addr  = pick_rx ? rx_addr : tx_addr;
        mem_wdata = pick_rx ? rx_wdata : 8'h00;
        rx_ack    = mem_ack & pick_rx;
        tx_ack    = mem_ack & ~pick_rx;
    end

    // Lock tracking: hold the owner from request until acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            own_rx_q <= 1'b0;
        end else if (mem_ack) begin
            locked_q <= 1'b0;
        end else if (mem_req) begin
            locked_q <= 1'b1;
            own_rx_q <= pick_rx;
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_rx_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_req) && rx_req && tx_req |-> mem_we);

endmodule

// File: rtl/sdma_tx_chan.sv
// Transmit channel.
// Does: on a non-zero length write, loops fetch-one-byte / send-one-byte,
//       advancing the pointer after each byte leaves on the stream.
// Assumes: the memory side returns read data in the cycle mem_ack is high.
module sdma_tx_chan #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              len_we,
    input  logic [ADDR_W-1:0] wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] ptr,
    output logic              busy
);
    import sdma_pkg::*;

    tx_state_e         state_q;
    logic [LEN_W-1:0]  left_q;
    logic [7:0]        byte_q;
    logic [LEN_W-1:0]  new_len;

    assign new_len  = wdata[LEN_W-1:0];
    assign busy     = (state_q != TXS_IDLE);
    assign mem_req  = (state_q == TXS_FETCH);
    assign mem_addr = ptr;
    assign tx_valid = (state_q == TXS_SEND);
    assign tx_data  = byte_q;

    // Fetch/send sequencer with pointer and length bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXS_IDLE;
            left_q  <= '0;
            byte_q  <= '0;
            ptr     <= '0;
        end else begin
            case (state_q)
                TXS_IDLE: begin
                    if (addr_we) begin
                        ptr <= wdata;
                    end else if (len_we && new_len != '0) begin
                        left_q  <= new_len;
                        state_q <= TXS_FETCH;
                    end
                end
                TXS_FETCH: begin
                    if (mem_ack) begin
                        byte_q  <= mem_rdata;
                        state_q <= TXS_SEND;
                    end
                end
                TXS_SEND: begin
                    if (tx_ready) begin
                        ptr     <= ptr + ADDR_W'(1);
                        left_q  <= left_q - LEN_W'(1);
                        state_q <= (left_q == LEN_W'(1)) ? TXS_IDLE : TXS_FETCH;
                    end
                end
                default: state_q <= TXS_IDLE;
            endcase
        end
    end

    assert_zero_len_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && len_we && new_len == '0 |=> !busy);

    assert_hold_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> ptr == $past(ptr) + ADDR_W'(1));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && addr_we && !(tx_valid && tx_ready) |=> $stable(ptr));

endmodule

// File: rtl/sdma_rx_chan.sv
// Receive channel.
// Does: on a length write, splits the request into a FIFO drain part and a
//       pending part; drains to memory, then writes diverted input bytes one
//       by one while the pending length is non-zero.
// Assumes: FCNT_W <= LEN_W; fifo_data shows the oldest byte whenever
//          fifo_count is non-zero and advances the cycle after fifo_pop.
module sdma_rx_chan #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int FCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              len_we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [FCNT_W-1:0] fifo_count,
    input  logic [7:0]        fifo_data,
    output logic              fifo_pop,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] ptr,
    output logic [LEN_W-1:0]  remaining,
    output logic              busy,
    output logic              divert
);
    import sdma_pkg::*;

    rx_state_e        state_q;
    logic [LEN_W-1:0] drain_left_q;
    logic [7:0]       wbuf_q;
    logic [LEN_W-1:0] req_len;
    logic [LEN_W-1:0] held;
    logic [LEN_W-1:0] drain_n;
    logic [LEN_W-1:0] short_n;

    // Split a new request into the part the FIFO covers and the shortfall
    always_comb begin
        req_len = wdata[LEN_W-1:0];
        held    = LEN_W'(fifo_count);
        if (held < req_len) begin
            drain_n = held;
            short_n = req_len - held;
        end else begin
            drain_n = req_len;
            short_n = '0;
        end
    end

    assign busy      = (state_q != RXS_IDLE);
    assign divert    = (remaining != '0);
    assign in_ready  = (state_q == RXS_IDLE) && divert && !addr_we && !len_we;
    assign mem_req   = (state_q == RXS_DRAIN) || (state_q == RXS_DIRECT);
    assign mem_addr  = ptr;
    assign mem_wdata = wbuf_q;
    assign fifo_pop  = (state_q == RXS_DRAIN) && mem_ack;

    // Drain / direct-write sequencer with pointer and length bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= RXS_IDLE;
            drain_left_q <= '0;
            wbuf_q       <= '0;
            ptr          <= '0;
            remaining    <= '0;
        end else begin
            case (state_q)
                RXS_IDLE: begin
                    if (addr_we) begin
                        ptr       <= wdata;
                        remaining <= '0;
                    end else if (len_we) begin
                        remaining    <= short_n;
                        drain_left_q <= drain_n;
                        if (drain_n != '0) state_q <= RXS_LOAD;
                    end else if (in_valid && in_ready) begin
                        wbuf_q  <= in_data;
                        state_q <= RXS_DIRECT;
                    end
                end
                RXS_LOAD: begin
                    wbuf_q  <= fifo_data;
                    state_q <= RXS_DRAIN;
                end
                RXS_DRAIN: begin
                    if (mem_ack) begin
                        ptr          <= ptr + ADDR_W'(1);
                        drain_left_q <= drain_left_q - LEN_W'(1);
                        state_q      <= (drain_left_q == LEN_W'(1)) ? RXS_IDLE : RXS_LOAD;
                    end
                end
                RXS_DIRECT: begin
                    if (mem_ack) begin
                        ptr       <= ptr + ADDR_W'(1);
                        remaining <= remaining - LEN_W'(1);
                        state_q   <= RXS_IDLE;
                    end
                end
                default: state_q <= RXS_IDLE;
            endcase
        end
    end

    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_count != '0);

    assert_short_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && len_we && !addr_we && LEN_W'(fifo_count) < wdata[LEN_W-1:0]
        |=> remaining == $past(wdata[LEN_W-1:0]) - LEN_W'($past(fifo_count)));

    assert_direct_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == RXS_DIRECT && mem_ack |=> remaining == $past(remaining) - LEN_W'(1));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && addr_we |=> remaining == '0 && !divert);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (addr_we || len_we) && !mem_ack |=> $stable(ptr) && $stable(remaining));

endmodule

// File: rtl/serial_dma_engine.sv
// Serial port DMA engine top level.
// Does: decodes the four register strobes, runs the transmit and receive
//       channels, and shares one byte-wide memory master port between them.
// Assumes: ADDR_W >= LEN_W; the serial front end honours rx_divert when
//          routing received bytes.
module serial_dma_engine #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int FCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] tx_ptr,
    output logic [ADDR_W-1:0] rx_ptr,
    output logic [LEN_W-1:0]  rx_remaining,
    output logic              tx_busy,
    output logic              rx_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic [FCNT_W-1:0] fifo_count,
    input  logic [7:0]        fifo_data,
    output logic              fifo_pop,
    input  logic              rx_in_valid,
    input  logic [7:0]        rx_in_data,
    output logic              rx_in_ready,
    output logic              rx_divert
);
    import sdma_pkg::*;

    reg_sel_e          sel;
    logic              tx_addr_we, tx_len_we, rx_addr_we, rx_len_we;
    logic              tx_req, tx_ack, rx_req, rx_ack;
    logic [ADDR_W-1:0] tx_maddr, rx_maddr;
    logic [7:0]        rx_mwdata;

    // Register strobe decode
    always_comb begin
        sel        = reg_sel_e'(cfg_wr_sel);
        tx_addr_we = cfg_wr_en && (sel == SEL_TX_ADDR);
        tx_len_we  = cfg_wr_en && (sel == SEL_TX_LEN);
        rx_addr_we = cfg_wr_en && (sel == SEL_RX_ADDR);
        rx_len_we  = cfg_wr_en && (sel == SEL_RX_LEN);
    end

    sdma_tx_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_we  (tx_addr_we),
        .len_we   (tx_len_we),
        .wdata    (cfg_wdata),
        .mem_req  (tx_req),
        .mem_addr (tx_maddr),
        .mem_ack  (tx_ack),
        .mem_rdata(mem_rdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .ptr      (tx_ptr),
        .busy     (tx_busy)
    );

    sdma_rx_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FCNT_W(FCNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_we   (rx_addr_we),
        .len_we    (rx_len_we),
        .wdata     (cfg_wdata),
        .fifo_count(fifo_count),
        .fifo_data (fifo_data),
        .fifo_pop  (fifo_pop),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .in_ready  (rx_in_ready),
        .mem_req   (rx_req),
        .mem_addr  (rx_maddr),
        .mem_wdata (rx_mwdata),
        .mem_ack   (rx_ack),
        .ptr       (rx_ptr),
        .remaining (rx_remaining),
        .busy      (rx_busy),
        .divert    (rx_divert)
    );

    sdma_mem_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_req   (rx_req),
        .rx_addr  (rx_maddr),
        .rx_wdata (rx_mwdata),
        .rx_ack   (rx_ack),
        .tx_req   (tx_req),
        .tx_addr  (tx_maddr),
        .tx_ack   (tx_ack),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !tx_busy && !rx_busy && !mem_req && rx_remaining == '0);

endmodule

// File: tb/tb_serial_dma_engine.sv
module tb_serial_dma_engine;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int FCNT_W = 5;

    // Receive table: {fifo fill, requested length, expected pending, expected drained}
    localparam logic [15:0] RX_TBL [5] = '{
        16'h4_2_0_2, 16'h3_3_0_3, 16'h2_5_3_2, 16'h0_4_4_0, 16'h5_0_0_0
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_wr_en;
    logic [1:0]        cfg_wr_sel;
    logic [ADDR_W-1:0] cfg_wdata;
    logic [ADDR_W-1:0] tx_ptr, rx_ptr;
    logic [LEN_W-1:0]  rx_remaining;
    logic              tx_busy, rx_busy;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              tx_valid, tx_ready;
    logic [7:0]        tx_data;
    logic [FCNT_W-1:0] fifo_count;
    logic [7:0]        fifo_data;
    logic              fifo_pop;
    logic              rx_in_valid, rx_in_ready, rx_divert;
    logic [7:0]        rx_in_data;

    int n_chk = 0;
    int n_bad = 0;
    int ack_delay = 0;
    logic stall = 1'b0;
    logic push_req = 1'b0, flush_req = 1'b0;
    logic [7:0] push_data = 8'h00;

    always #10 clk = ~clk;

    serial_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FCNT_W(FCNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wdata(cfg_wdata), .tx_ptr(tx_ptr), .rx_ptr(rx_ptr),
        .rx_remaining(rx_remaining), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .fifo_count(fifo_count), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_in_ready(rx_in_ready), .rx_divert(rx_divert)
    );

    // Memory model: reads return a function of the address, writes are kept
    logic [7:0] wmem [0:255];
    int wait_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_cnt <= 0;
            mem_rdata <= 8'h00;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= ack_delay) begin
                    mem_ack <= 1'b1;
                    wait_cnt <= 0;
                    if (mem_we) wmem[mem_addr[7:0]] <= mem_wdata;
                    else mem_rdata <= mem_addr[7:0] * 8'd7 + 8'd3;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    // Receive FIFO model
    logic [7:0] fq [0:31];
    int fhead, fcnt;
    assign fifo_count = FCNT_W'(fcnt);
    assign fifo_data  = fq[fhead];
    always @(posedge clk) begin
        if (!rst_n || flush_req) begin
            fhead <= 0;
            fcnt <= 0;
        end else begin
            if (push_req) fq[(fhead + fcnt) % 32] <= push_data;
            if (fifo_pop) fhead <= (fhead + 1) % 32;
            fcnt <= fcnt + (push_req ? 1 : 0) - (fifo_pop ? 1 : 0);
        end
    end

    // Transmit sink with optional backpressure
    logic [7:0] tx_log [0:63];
    int tx_n;
    always @(posedge clk) begin
        if (!rst_n) begin
            tx_ready <= 1'b1;
            tx_n <= 0;
        end else begin
            tx_ready <= stall ? ~tx_ready : 1'b1;
            if (tx_valid && tx_ready) begin
                tx_log[tx_n % 64] <= tx_data;
                tx_n <= tx_n + 1;
            end
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_sel = sel;
        cfg_wdata = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        push_req = 1'b1;
        push_data = b;
        @(negedge clk);
        push_req = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while ((tx_busy || rx_busy) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    task automatic send_direct(input logic [7:0] b);
        int t = 0;
        @(negedge clk);
        rx_in_valid = 1'b1;
        rx_in_data = b;
        while (!rx_in_ready && t < 1000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        rx_in_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        int n0;
        rst_n = 1'b0;
        cfg_wr_en = 1'b0;
        cfg_wr_sel = 2'd0;
        cfg_wdata = '0;
        rx_in_valid = 1'b0;
        rx_in_data = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 tx_busy", int'(tx_busy), 0);
        check("R1 rx_busy", int'(rx_busy), 0);
        check("R1 mem_req", int'(mem_req), 0);
        check("R1 tx_valid", int'(tx_valid), 0);
        check("R1 rx_divert", int'(rx_divert), 0);
        check("R1 rx_remaining", int'(rx_remaining), 0);
        check("R1 pointers", int'(tx_ptr) + int'(rx_ptr), 0);

        // Receive table: R6 / R7 drain split
        for (int r = 0; r < 5; r++) begin
            int fill, len, erem, edr;
            logic [ADDR_W-1:0] base;
            fill = int'(RX_TBL[r][15:12]);
            len  = int'(RX_TBL[r][11:8]);
            erem = int'(RX_TBL[r][7:4]);
            edr  = int'(RX_TBL[r][3:0]);
            base = ADDR_W'(16'h0100 + r * 16);
            ack_delay = r % 3;
            flush();
            cfg_write(2'd2, base);
            for (int i = 0; i < fill; i++) push(8'(8'h40 + r * 16 + i));
            cfg_write(2'd3, ADDR_W'(len));
            wait_idle();
            check(erem != 0 ? "R7 pending length" : "R6 pending length", int'(rx_remaining), erem);
            check("R6 rx_ptr end", int'(rx_ptr), int'(base) + edr);
            check("R6 fifo left", int'(fifo_count), fill - edr);
            for (int i = 0; i < edr; i++)
                check("R6 drained byte", int'(wmem[8'(int'(base[7:0]) + i)]), (8'h40 + r * 16 + i) & 255);
        end

        // R2: basic transmit
        ack_delay = 1;
        n0 = tx_n;
        cfg_write(2'd0, 16'h0020);
        cfg_write(2'd1, 16'd5);
        wait_idle();
        check("R2 byte count", tx_n - n0, 5);
        for (int i = 0; i < 5; i++)
            check("R2 byte value", int'(tx_log[(n0 + i) % 64]), ((8'h20 + i) * 7 + 3) & 255);
        check("R2 tx_ptr end", int'(tx_ptr), 16'h0025);

        // R3: zero transmit length
        n0 = tx_n;
        cfg_write(2'd1, 16'd0);
        check("R3 busy stays low", int'(tx_busy), 0);
        repeat (5) @(negedge clk);
        check("R3 no byte sent", tx_n - n0, 0);
        check("R3 tx_ptr kept", int'(tx_ptr), 16'h0025);

        // R4: transmit under backpressure
        ack_delay = 0;
        stall = 1'b1;
        n0 = tx_n;
        cfg_write(2'd0, 16'h0040);
        cfg_write(2'd1, 16'd4);
        wait_idle();
        stall = 1'b0;
        check("R4 byte count", tx_n - n0, 4);
        for (int i = 0; i < 4; i++)
            check("R4 byte value", int'(tx_log[(n0 + i) % 64]), ((8'h40 + i) * 7 + 3) & 255);

        // R8 / R9: diverted bytes, then cancel
        flush();
        cfg_write(2'd2, 16'h0090);
        cfg_write(2'd3, 16'd5);
        wait_idle();
        check("R8 divert raised", int'(rx_divert), 1);
        check("R8 ready when idle", int'(rx_in_ready), 1);
        send_direct(8'hA1);
        send_direct(8'hA2);
        check("R8 direct byte 0", int'(wmem[8'h90]), 8'hA1);
        check("R8 direct byte 1", int'(wmem[8'h91]), 8'hA2);
        check("R8 remaining", int'(rx_remaining), 3);
        check("R8 rx_ptr", int'(rx_ptr), 16'h0092);
        cfg_write(2'd2, 16'h00B0);
        check("R9 cancel remaining", int'(rx_remaining), 0);
        check("R9 rx_ptr loaded", int'(rx_ptr), 16'h00B0);
        check("R9 divert dropped", int'(rx_divert), 0);
        cfg_write(2'd3, 16'd1);
        send_direct(8'hC5);
        check("R8 last byte", int'(wmem[8'hB0]), 8'hC5);
        check("R8 remaining zero", int'(rx_remaining), 0);
        check("R8 divert falls", int'(rx_divert), 0);

        // R10: writes while busy are ignored
        ack_delay = 3;
        n0 = tx_n;
        cfg_write(2'd0, 16'h0060);
        cfg_write(2'd1, 16'd6);
        check("R10 tx busy", int'(tx_busy), 1);
        cfg_write(2'd1, 16'd2);
        cfg_write(2'd0, 16'h0000);
        wait_idle();
        check("R10 tx count kept", tx_n - n0, 6);
        check("R10 tx_ptr end", int'(tx_ptr), 16'h0066);
        flush();
        cfg_write(2'd2, 16'h00D0);
        for (int i = 0; i < 3; i++) push(8'(8'hD0 + i));
        cfg_write(2'd3, 16'd3);
        check("R10 rx busy", int'(rx_busy), 1);
        cfg_write(2'd2, 16'h00E0);
        cfg_write(2'd3, 16'd7);
        wait_idle();
        check("R10 rx_ptr end", int'(rx_ptr), 16'h00D3);
        check("R10 rx remaining", int'(rx_remaining), 0);
        check("R10 rx last byte", int'(wmem[8'hD2]), 8'hD2);

        // R11: both channels at once
        ack_delay = 1;
        flush();
        n0 = tx_n;
        cfg_write(2'd0, 16'h0010);
        cfg_write(2'd2, 16'h00F0);
        for (int i = 0; i < 3; i++) push(8'(8'hE0 + i));
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 2'd3; cfg_wdata = 16'd3;
        @(negedge clk);
        cfg_wr_sel = 2'd1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        wait_idle();
        check("R11 tx count", tx_n - n0, 3);
        for (int i = 0; i < 3; i++) begin
            check("R11 tx byte", int'(tx_log[(n0 + i) % 64]), ((8'h10 + i) * 7 + 3) & 255);
            check("R11 rx byte", int'(wmem[8'(8'hF0 + i)]), 8'hE0 + i);
        end
        check("R11 rx_ptr", int'(rx_ptr), 16'h00F3);
        check("R11 tx_ptr", int'(tx_ptr), 16'h0013);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule